// File: doc/BRIEF.md
# Signed Arithmetic and Logic Unit with Flags

This block is a purely combinational datapath unit that takes two operand words and a 4-bit operation code, and returns a result word with two status outputs. One output reports that the result is entirely zero. The other reports signed two's-complement overflow. The operand width is a parameter with a default of 32 bits. The code space holds 16 entries, and six of them are assigned: bitwise and, or and nor, signed add, signed subtract and signed set-on-less-than.

A single-cycle processor uses it for register-register arithmetic, immediate arithmetic and address generation. The control logic drives the operation code. The zero output drives the equality branch decision. The result value is computed in one process and the two flags in another, so the flag logic can be read and timed on its own. Any code that is not assigned yields a result of zero. That gives software and the control logic a defined value even when a decode goes wrong.

Top module: `alu_signed`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of the two operands.
- R2: Code 4'b0001 returns the bitwise OR, and code 4'b1100 returns the bitwise NOR, of the two operands.
- R3: Code 4'b0010 returns the two's-complement sum, wrapped to the operand width. Overflow is 1 exactly when both operands have the same sign bit and the sum's sign bit differs from it.
- R4: Code 4'b0110 returns the difference A minus B, wrapped to the operand width. Overflow is 1 exactly when the operands' sign bits differ and the difference's sign bit differs from A's.
- R5: Code 4'b0111 returns 1 when A is less than B as signed values and 0 otherwise, with all upper bits 0. The answer is correct even when A minus B overflows.
- R6: Overflow is 0 for the and, or, nor and set-on-less-than codes.
- R7: Every other code (3, 4, 5, 8 to 11, 13 to 15) returns a result of 0 with overflow 0.
- R8: The zero output is 1 exactly when every bit of the result is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 32 | First operand, A |
| opb | input | 32 | Second operand, B |
| op | input | 4 | Operation code |
| res | output | 32 | Result word |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of add or subtract |

## Verification
The table tries each operation with mixed bit patterns, with all-ones and all-zero words, and with the extreme signed values.

Sums and differences of the extreme values separate the correct overflow rule from a simple carry-out test. They also check that a wrapped result of zero still raises the zero flag.

The set-on-less-than cases pair the most negative value with the most positive value in both orders. These pairs tell a plain sign-of-difference compare, which fails when the subtraction overflows, apart from the corrected signed compare.

A sweep over every unassigned code then checks that each returns zero, with overflow clear and the zero flag raised.

// File: rtl/alu_signed.sv
module alu_signed #(
  parameter int W     = 32,
  parameter int NFUNC = 16
) (
  input  logic [W-1:0]             opa,
  input  logic [W-1:0]             opb,
  input  logic [$clog2(NFUNC)-1:0] op,
  output logic [W-1:0]             res,
  output logic                     zero,
  output logic                     ovf
);
  localparam int CW = $clog2(NFUNC);
  localparam logic [CW-1:0] OP_AND = CW'(0);
  localparam logic [CW-1:0] OP_OR  = CW'(1);
  localparam logic [CW-1:0] OP_ADD = CW'(2);
  localparam logic [CW-1:0] OP_SUB = CW'(6);
  localparam logic [CW-1:0] OP_SLT = CW'(7);
  localparam logic [CW-1:0] OP_NOR = CW'(12);

  logic [W-1:0] sum, diff;
  logic add_v, sub_v, less;

  assign sum   = opa + opb;
  assign diff  = opa - opb;
  assign add_v = (opa[W-1] == opb[W-1]) && (sum[W-1] != opa[W-1]);
  assign sub_v = (opa[W-1] != opb[W-1]) && (diff[W-1] != opa[W-1]);
  assign less  = diff[W-1] ^ sub_v;

  // result process
  always_comb begin
    case (op)
      OP_AND:  res = opa & opb;
      OP_OR:   res = opa | opb;
      OP_NOR:  res = ~(opa | opb);
      OP_ADD:  res = sum;
      OP_SUB:  res = diff;
      OP_SLT:  res = {{(W-1){1'b0}}, less};
      default: res = '0;
    endcase
  end

  // flag process
  always_comb begin
    zero = (res == '0);
    case (op)
      OP_ADD:  ovf = add_v;
      OP_SUB:  ovf = sub_v;
      default: ovf = 1'b0;
    endcase

    p_ovf_arith_only_r6: assert (!ovf || op == OP_ADD || op == OP_SUB)
      else $error("overflow raised for a non-arithmetic code");
    p_slt_single_bit_r5: assert (op != OP_SLT || res[W-1:1] == '0)
      else $error("compare result has upper bits set");
    p_sub_zero_equal_r8: assert (!(op == OP_SUB && zero) || opa == opb)
      else $error("zero difference from unequal operands");
    p_and_subset_r1: assert (op != OP_AND || (res & ~opa) == '0)
      else $error("and result has bits outside operand A");
  end
endmodule

// File: tb/sim_alu_signed.sv
module sim_alu_signed;
  localparam int W = 32;
  localparam int NV = 22;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] opa, opb, res;
  logic [3:0] op;
  logic zero, ovf;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  alu_signed u0 (.opa(opa), .opb(opb), .op(op), .res(res), .zero(zero), .ovf(ovf));

  // {op, a, b}
  localparam logic [67:0] VEC [NV] = '{
    {4'd0,  32'hF0F0F0F0, 32'h0FF00FF0},
    {4'd0,  32'h12345678, 32'h00000000},
    {4'd1,  32'h0F0F0000, 32'h0000F0F0},
    {4'd12, 32'h00000000, 32'h00000000},
    {4'd12, 32'hFFFFFFFF, 32'h00000000},
    {4'd2,  32'h00000005, 32'h00000007},
    {4'd2,  32'h7FFFFFFF, 32'h00000001},
    {4'd2,  32'h80000000, 32'h80000000},
    {4'd2,  32'hFFFFFFFF, 32'h00000001},
    {4'd2,  32'h80000000, 32'h7FFFFFFF},
    {4'd6,  32'h00000010, 32'h00000003},
    {4'd6,  32'h80000000, 32'h00000001},
    {4'd6,  32'h7FFFFFFF, 32'hFFFFFFFF},
    {4'd6,  32'h00000005, 32'h00000005},
    {4'd6,  32'h00000000, 32'h80000000},
    {4'd7,  32'hFFFFFFFF, 32'h00000001},
    {4'd7,  32'h00000001, 32'hFFFFFFFF},
    {4'd7,  32'h80000000, 32'h7FFFFFFF},
    {4'd7,  32'h7FFFFFFF, 32'h80000000},
    {4'd7,  32'h00000004, 32'h00000004},
    {4'd0,  32'h80000000, 32'h80000000},
    {4'd3,  32'h0000FFFF, 32'h0000FFFF}
  };

  function automatic string tag_of(input logic [3:0] c);
    case (c)
      4'd0:  return "R1";
      4'd1:  return "R2";
      4'd12: return "R2";
      4'd2:  return "R3";
      4'd6:  return "R4";
      4'd7:  return "R5";
      default: return "R7";
    endcase
  endfunction

  task automatic ref_model(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b,
                           output logic [W-1:0] r, output logic v);
    longint sa, sb, s;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    v = 1'b0;
    case (c)
      4'd0:  r = a & b;
      4'd1:  r = a | b;
      4'd12: r = ~(a | b);
      4'd2: begin s = sa + sb; r = s[W-1:0]; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd6: begin s = sa - sb; r = s[W-1:0]; v = (s > 64'sd2147483647) || (s < -64'sd2147483648); end
      4'd7:  r = (sa < sb) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
  endtask

  task automatic check(input string tag, input string what, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  task automatic apply(input logic [3:0] c, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] er;
    logic ev;
    @(negedge clk);
    op = c; opa = a; opb = b;
    @(posedge clk); #1;
    ref_model(c, a, b, er, ev);
    check(tag_of(c), "result", res, er);
    check("R8", "zero", {31'd0, zero}, {31'd0, er == '0});
    if (c == 4'd0 || c == 4'd1 || c == 4'd12 || c == 4'd7)
      check("R6", "overflow", {31'd0, ovf}, {31'd0, ev});
    else
      check(tag_of(c), "overflow", {31'd0, ovf}, {31'd0, ev});
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    op = 4'd0; opa = '0; opb = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // idle state after start-up: and of zeros
    check("R8", "start zero", {31'd0, zero}, 32'd1);
    check("R1", "start result", res, 32'd0);
    check("R6", "start overflow", {31'd0, ovf}, 32'd0);

    for (int i = 0; i < NV; i++)
      apply(VEC[i][67:64], VEC[i][63:32], VEC[i][31:0]);

    // R7: every unassigned code with operands that would give nonzero results
    for (int c = 0; c < 16; c++) begin
      if (c != 0 && c != 1 && c != 2 && c != 6 && c != 7 && c != 12)
        apply(4'(c), 32'h7FFFFFFF, 32'h00000001);
    end

    // R5 and R3 extra corners: equal extremes, wrap to zero
    apply(4'd7, 32'h80000000, 32'h80000000);
    apply(4'd7, 32'h80000000, 32'h00000000);
    apply(4'd2, 32'h00000001, 32'hFFFFFFFF);
    apply(4'd6, 32'h80000000, 32'h80000000);
    apply(4'd12, 32'hAAAAAAAA, 32'h55555555);

    finish_run();
  end
endmodule